// File: doc/BRIEF.md
# Two-wire serial slave with nonvolatile write-busy polling

This block is the serial front end of a small register-based peripheral whose backing store is slow nonvolatile memory. It watches the two bus lines (a clock and an open-drain data line) in the system clock domain. It finds START and STOP conditions and takes in the address byte that follows a START. It selects itself only when the upper nibble of that byte holds the fixed device-type code and the next three bits equal three strap pins. It then either accepts a register index and data bytes, or returns register data.

The register space covers two potentiometer channels, each with two wipers. Every wiper has one volatile control register and four nonvolatile data registers. When a write to a nonvolatile register is closed by STOP, an internal busy window opens. The window models the slow programming cycle and lasts a parameterised number of clocks. While it is open, the slave gives no acknowledge to its own address, whatever the direction bit is, and so every command is ignored. A master finds out that the cycle has finished by sending the address repeatedly until it is acknowledged. The register storage itself sits outside the block, behind a simple write-strobe and read-data port.

Top module: `twi_nvbusy_slave`

## Requirements
- R1: The slave acknowledges an address byte only if bits 7..4 equal binary 0101. With any other code it acknowledges nothing and issues no register write until the next START.
- R2: Address bits 3, 2 and 1 must equal strap[2], strap[1] and strap[0]. Any mismatch is treated as in R1.
- R3: Address bit 0 selects the direction. With 0 (write), the next byte is a register index. With 1 (read), the slave drives the selected register's data MSB first, starting at the SCL falling edge that ends the address acknowledge.
- R4: The index byte encodes the register as follows: bit 4 is 1 for nonvolatile, bits 3..2 give the wiper (bit 3 channel, bit 2 wiper in channel), bits 1..0 give the nonvolatile slot, and bits 7..5 are ignored. reg_addr carries bits 4..0. Each data byte after the index is acknowledged and gives a one-cycle reg_we pulse with reg_wdata equal to that byte.
- R5: The acknowledge pulls SDA low from the falling SCL edge after the eighth bit, and SDA is released at the falling edge that ends the ninth clock.
- R6: A write that included at least one data byte to a nonvolatile register and is ended by STOP raises nv_busy for exactly BUSY_CYCLES clocks.
- R7: A write to a volatile register, or a nonvolatile write ended by a repeated START instead of STOP, does not start the busy window.
- R8: While nv_busy is high, a matching address is not acknowledged for either value of the direction bit, and no reg_we pulse is issued.
- R9: Once the busy window ends, a matching address is acknowledged again and reads and writes work normally.
- R10: A START inside a byte abandons the transfer and restarts address reception. The partial byte causes no register write.
- R11: During a read, a master acknowledge makes the slave send the same register again. A master no-acknowledge makes the slave release SDA until the next START or STOP.
- R12: In reset, sda_oe, reg_we and nv_busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| strap | input | 3 | Address strap pins, compared with address bits 3..1 |
| nv_busy | output | 1 | Nonvolatile programming window in progress |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 5 | Selected register index |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Data of the register selected by reg_addr |

## Verification
The assertions assume that each SCL phase lasts several system clocks longer than the synchronizer delay, and that SDA changes only while SCL is low, except when the master forms a START or STOP. Under these conditions every change of the slave's pull-down follows an SCL falling edge, and an address is accepted only when type, strap and idle state all agree. The bench holds each SCL phase for ten clocks and moves SDA only two clocks after SCL has fallen. It never forms a START or STOP while the slave may be driving the line, and it polls for readiness with the write direction only.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned STRAP_W = 3;
  localparam int unsigned TYPE_W  = 4;
  localparam logic [TYPE_W-1:0] DEV_TYPE = 4'b0101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INDEX,
    ST_INDEX_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } xfer_state_t;

  typedef struct packed {
    logic       nv;
    logic [1:0] wiper;
    logic [1:0] slot;
  } reg_sel_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic [SYNC_STAGES-1:0] scl_pipe_d, sda_pipe_d;
  logic scl_prev_q, sda_prev_q;
  logic scl_s;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[LAST];
      sda_prev_q <= sda_pipe_q[LAST];
    end
  end

  assign scl_s     = scl_pipe_q[LAST];
  assign sda_s     = sda_pipe_q[LAST];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? LOAD_VAL : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o); // R6
endmodule

// File: rtl/twi_xfer_ctrl.sv
module twi_xfer_ctrl
  import twi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [STRAP_W-1:0]   strap_i,
  input  logic                 busy_i,
  input  logic [BYTE_W-1:0]    rdata_i,
  output logic                 sda_oe_o,
  output logic                 we_o,
  output logic [IDX_W-1:0]     addr_o,
  output logic [BYTE_W-1:0]    wdata_o,
  output logic                 commit_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LASTB = CNT_W'(BYTE_W - 1);

  xfer_state_t        state_q, state_d;
  logic [CNT_W-1:0]   bcnt_q, bcnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [BYTE_W-1:0]  wdata_q, wdata_d;
  reg_sel_t           idx_q, idx_d;
  logic               rw_q, rw_d;
  logic               nvpend_q, nvpend_d;
  logic               oe_q, oe_d;
  logic               we_q, we_d;
  logic               mack_q, mack_d;
  logic               addr_hit;
  logic               rx_state;

  assign addr_hit = (sh_q[BYTE_W-1 -: TYPE_W] == DEV_TYPE) &&
                    (sh_q[STRAP_W:1] == strap_i) && !busy_i;
  assign rx_state = (state_q == ST_ADDR) || (state_q == ST_INDEX) ||
                    (state_q == ST_WDATA);

  always_comb begin
    state_d  = state_q;
    bcnt_d   = bcnt_q;
    sh_d     = sh_q;
    wdata_d  = wdata_q;
    idx_d    = idx_q;
    rw_d     = rw_q;
    nvpend_d = nvpend_q;
    oe_d     = oe_q;
    mack_d   = mack_q;
    we_d     = 1'b0;
    commit_o = 1'b0;
    if (start_det) begin
      state_d  = ST_ADDR;
      bcnt_d   = '0;
      oe_d     = 1'b0;
      nvpend_d = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      oe_d     = 1'b0;
      commit_o = nvpend_q & ~busy_i;
      nvpend_d = 1'b0;
    end else if (rx_state) begin
      if (scl_rise && (bcnt_q != FULL)) begin
        sh_d   = {sh_q[BYTE_W-2:0], sda_s};
        bcnt_d = bcnt_q + CNT_W'(1);
      end else if (scl_fall && (bcnt_q == FULL)) begin
        bcnt_d = '0;
        if (state_q == ST_ADDR) begin
          if (addr_hit) begin
            state_d = ST_ADDR_ACK;
            oe_d    = 1'b1;
            rw_d    = sh_q[0];
          end else begin
            state_d = ST_SKIP;
          end
        end else if (state_q == ST_INDEX) begin
          idx_d   = reg_sel_t'(sh_q[IDX_W-1:0]);
          state_d = ST_INDEX_ACK;
          oe_d    = 1'b1;
        end else begin
          we_d     = 1'b1;
          wdata_d  = sh_q;
          nvpend_d = nvpend_q | idx_q.nv;
          state_d  = ST_WDATA_ACK;
          oe_d     = 1'b1;
        end
      end
    end else begin
      unique case (state_q)
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_d = ST_RDATA;
              sh_d    = rdata_i;
              oe_d    = ~rdata_i[BYTE_W-1];
              bcnt_d  = '0;
            end else begin
              state_d = ST_INDEX;
              oe_d    = 1'b0;
            end
          end
        end
        ST_INDEX_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            state_d = ST_WDATA;
            oe_d    = 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bcnt_q == LASTB) begin
              state_d = ST_RACK;
              oe_d    = 1'b0;
              bcnt_d  = '0;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d   = ~sh_q[BYTE_W-2];
              bcnt_d = bcnt_q + CNT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              sh_d    = rdata_i;
              oe_d    = ~rdata_i[BYTE_W-1];
              bcnt_d  = '0;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bcnt_q   <= '0;
      sh_q     <= '0;
      wdata_q  <= '0;
      idx_q    <= '0;
      rw_q     <= 1'b0;
      nvpend_q <= 1'b0;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bcnt_q   <= bcnt_d;
      sh_q     <= sh_d;
      wdata_q  <= wdata_d;
      idx_q    <= idx_d;
      rw_q     <= rw_d;
      nvpend_q <= nvpend_d;
      oe_q     <= oe_d;
      we_q     <= we_d;
      mack_q   <= mack_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign we_o     = we_q;
  assign addr_o   = idx_q;
  assign wdata_o  = wdata_q;

  AST_ADDR_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR)
      |-> ($past(sh_q[BYTE_W-1 -: TYPE_W]) == DEV_TYPE)); // R1
  AST_ADDR_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR)
      |-> ($past(sh_q[STRAP_W:1]) == $past(strap_i))); // R2
  AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR) |-> !$past(busy_i)); // R8
  AST_OE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R5
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q); // R4
endmodule

// File: rtl/twi_nvbusy_slave.sv
module twi_nvbusy_slave
  import twi_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  output logic               nv_busy,
  output logic               reg_we,
  output logic [IDX_W-1:0]   reg_addr,
  output logic [BYTE_W-1:0]  reg_wdata,
  input  logic [BYTE_W-1:0]  reg_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_xfer_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap_i   (strap),
    .busy_i    (nv_busy),
    .rdata_i   (reg_rdata),
    .sda_oe_o  (sda_oe),
    .we_o      (reg_we),
    .addr_o    (reg_addr),
    .wdata_o   (reg_wdata),
    .commit_o  (commit)
  );

  twi_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (commit),
    .busy_o (nv_busy)
  );

  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_we |-> !nv_busy); // R8
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(nv_busy) |-> $past(stop_det)); // R6
endmodule

// File: tb/sim_twi_nvbusy_slave.sv
`timescale 1ns/1ps
module sim_twi_nvbusy_slave;
  localparam int BUSY = 3000;
  localparam int HALF = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_pull;
  logic sda_oe, nv_busy, reg_we;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] rf [32];
  logic [7:0] expv [32];
  int n_checks = 0, n_err = 0;
  int cyc = 0, we_cnt = 0, busy_cnt = 0;

  always #10 clk = ~clk;

  assign sda_line = ~(m_pull | sda_oe);

  twi_nvbusy_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(STRAP), .nv_busy(nv_busy), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (nv_busy) busy_cnt <= busy_cnt + 1;
  end
  assign reg_rdata = rf[reg_addr];

  function automatic logic [7:0] addr_b(input logic rw);
    return {4'b0101, STRAP, rw};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_pull = 1'b0; tick(HALF);
    m_scl = 1'b1;  tick(HALF);
    m_pull = 1'b1; tick(HALF);
    m_scl = 1'b0;  tick(2);
  endtask

  task automatic bus_stop();
    m_pull = 1'b1; tick(HALF);
    m_scl = 1'b1;  tick(HALF);
    m_pull = 1'b0; tick(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_pull = ~b[i]; tick(HALF - 2);
      m_scl = 1'b1;   tick(HALF);
      m_scl = 1'b0;   tick(2);
    end
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_pull = 1'b0; tick(HALF - 2);
    m_scl = 1'b1;  tick(HALF / 2);
    ack = ~sda_line;
    tick(HALF / 2);
    m_scl = 1'b0;  tick(2);
  endtask

  task automatic recv(input bit mack, output logic [7:0] d);
    d = '0;
    m_pull = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(HALF - 2);
      m_scl = 1'b1; tick(HALF / 2);
      d = {d[6:0], sda_line};
      tick(HALF / 2);
      m_scl = 1'b0; tick(2);
    end
    m_pull = mack; tick(HALF - 2);
    m_scl = 1'b1;  tick(HALF);
    m_scl = 1'b0;  tick(2);
    m_pull = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] ab, input logic [4:0] idx, input logic [7:0] d,
                          output bit aa, output bit ai, output bit ad);
    bus_start();
    send(ab, aa);
    send({3'b000, idx}, ai);
    send(d, ad);
    bus_stop();
  endtask

  task automatic reg_read(input logic [4:0] idx, output logic [7:0] d, output bit ok);
    bit a1, a2, a3;
    bus_start();
    send(addr_b(1'b0), a1);
    send({3'b111, idx}, a2);
    bus_start();
    send(addr_b(1'b1), a3);
    recv(1'b0, d);
    bus_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic poll(input logic rw, output bit ack);
    bus_start();
    send(addr_b(rw), ack);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit aa, ai, ad, ok;
    logic [7:0] d, ab;
    logic [4:0] idx;
    int we0, t0, b0, polls;
    bit bad;
    for (int i = 0; i < 32; i++) begin
      rf[i] = 8'h00;
      expv[i] = 8'h00;
    end
    void'($urandom(32'h2f1c5));
    m_scl = 1'b1; m_pull = 1'b0; rst_n = 1'b0;
    tick(5);
    chk("R12 sda_oe in reset", sda_oe, 0);
    chk("R12 busy in reset", nv_busy, 0);
    chk("R12 we in reset", reg_we, 0);
    rst_n = 1'b1;
    tick(10);
    chk("R12 busy after reset", nv_busy, 0);

    // directed volatile write with acknowledge timing
    we0 = we_cnt;
    bus_start();
    send(addr_b(1'b0), aa);
    chk("R3 write address ack", aa, 1);
    send(8'h08, ai);
    chk("R4 index ack", ai, 1);
    send(8'hA5, ad);
    chk("R5 data ack low in ninth clock", ad, 1);
    tick(4);
    chk("R5 released after ninth clock", sda_oe, 0);
    bus_stop();
    expv[8] = 8'hA5;
    chk("R4 one write strobe", we_cnt - we0, 1);
    chk("R4 register data", rf[8], 8'hA5);
    tick(20);
    chk("R7 volatile write no busy", nv_busy, 0);

    // read back, then multi-byte read with master ack
    reg_read(5'h08, d, ok);
    chk("R3 read acks", ok, 1);
    chk("R3 read data", d, 8'hA5);
    bus_start();
    send(addr_b(1'b0), aa);
    send(8'h08, ai);
    bus_start();
    send(addr_b(1'b1), aa);
    recv(1'b1, d);
    chk("R11 first byte", d, 8'hA5);
    recv(1'b0, d);
    chk("R11 repeated byte after master ack", d, 8'hA5);
    tick(HALF);
    chk("R11 released after master nack", sda_oe, 0);
    bus_stop();

    // wrong device type and wrong strap bits
    we0 = we_cnt;
    do_write({4'b0110, STRAP, 1'b0}, 5'h08, 8'h11, aa, ai, ad);
    chk("R1 wrong type nack", aa, 0);
    chk("R1 wrong type no write", we_cnt - we0, 0);
    for (int k = 0; k < 3; k++) begin
      ab = addr_b(1'b0) ^ (8'h02 << k);
      do_write(ab, 5'h08, 8'h22, aa, ai, ad);
      chk("R2 strap mismatch nack", aa, 0);
    end
    chk("R2 strap mismatch no write", we_cnt - we0, 0);
    chk("R2 register unchanged", rf[8], 8'hA5);

    // random volatile traffic with corrupted addresses mixed in
    for (int t = 0; t < 40; t++) begin
      idx = {1'b0, 4'($urandom)};
      d = 8'($urandom);
      bad = ($urandom % 4) == 0;
      ab = addr_b(1'b0);
      if (bad) ab = ab ^ (8'h02 << ($urandom % 7));
      we0 = we_cnt;
      do_write(ab, idx, d, aa, ai, ad);
      chk("R1 R2 address decision", aa, !bad);
      chk("R4 write strobe count", we_cnt - we0, bad ? 0 : 1);
      if (!bad) expv[idx] = d;
    end
    for (int i = 0; i < 16; i++) begin
      reg_read(5'(i), d, ok);
      chk("R4 readback", d, expv[i]);
    end

    // START inside a data byte
    we0 = we_cnt;
    bus_start();
    send(addr_b(1'b0), aa);
    send(8'h03, ai);
    send_bits(8'hFF, 4);
    reg_read(5'h03, d, ok);
    chk("R10 restart accepted", ok, 1);
    chk("R10 partial byte not written", d, expv[3]);
    chk("R10 no strobe", we_cnt - we0, 0);

    // nonvolatile write ended by repeated START
    bus_start();
    send(addr_b(1'b0), aa);
    send(8'h11, ai);
    send(8'h3C, ad);
    bus_start();
    send(addr_b(1'b0), aa);
    bus_stop();
    expv[5'h11] = 8'h3C;
    tick(50);
    chk("R7 repeated start no busy", nv_busy, 0);
    reg_read(5'h11, d, ok);
    chk("R7 device still ready", ok, 1);
    chk("R7 data", d, 8'h3C);

    // nonvolatile write ended by STOP, then polling
    b0 = busy_cnt;
    do_write(addr_b(1'b0), 5'h12, 8'h77, aa, ai, ad);
    t0 = cyc;
    expv[5'h12] = 8'h77;
    tick(10);
    chk("R6 busy started", nv_busy, 1);
    poll(1'b0, aa);
    chk("R8 write poll nack", aa, 0);
    poll(1'b1, aa);
    chk("R8 read poll nack", aa, 0);
    we0 = we_cnt;
    do_write(addr_b(1'b0), 5'h12, 8'h00, aa, ai, ad);
    chk("R8 command nack", aa, 0);
    chk("R8 command ignored", we_cnt - we0, 0);
    polls = 0;
    aa = 1'b0;
    while (!aa && polls < 40) begin
      poll(1'b0, aa);
      polls++;
    end
    chk("R9 ack after busy", aa, 1);
    chk("R9 not before window", (cyc - t0) >= BUSY - HALF, 1);
    chk("R9 soon after window", (cyc - t0) <= BUSY + 600, 1);
    chk("R6 busy length", busy_cnt - b0, BUSY);
    reg_read(5'h12, d, ok);
    chk("R9 normal read", ok, 1);
    chk("R9 nonvolatile data", d, 8'h77);

    finish_run();
  end
endmodule